// File: doc/BRIEF.md
# Keyed One-Time-Enable Watchdog Timer

This block is a watchdog for a small controller core. After reset it sits idle. Software arms it by writing a two-byte key to a write-only watchdog register. Once armed, a 14-bit counter advances on every machine-cycle tick. If software does not repeat the key in time, the counter overflows. The block then raises a one-cycle reset request for the chip and drives a reset-out line for a fixed number of oscillator (clock) periods.

Software cannot turn the watchdog off. Only a hardware reset, or the watchdog's own overflow, returns it to the idle state. A control bit in a separate auxiliary register suppresses the reset-out line. The one-cycle reset request still fires when that bit is set. Generating the machine-cycle tick and driving the external reset pad are left to the surrounding logic.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `wdt_rst` and `rst_pin_drv` are 0 and the watchdog is disarmed.
- R2: The watchdog arms only when a write of 0x1E to address 0xA6 is followed, as the very next write, by a write of 0xE1 to address 0xA6. Cycles without a write do not break the pair. The counter starts from zero at the second write.
- R3: Three cases leave the watchdog disarmed: a write to any address between the two key bytes, a second byte other than 0xE1, or 0xE1 without a preceding 0x1E.
- R4: While armed, the 14-bit counter advances by one on each cycle with `mc_tick` high. The 16384th tick after arming makes `wdt_rst` high for exactly the following clock cycle. Cycles with `mc_tick` low do not advance the counter.
- R5: Writing the key pair again while armed clears the counter. The next overflow then comes 16384 ticks after the second byte of that pair.
- R6: No write disarms the watchdog. A write of any other value to 0xA6 leaves the pending overflow time unchanged.
- R7: The overflow disarms the watchdog and clears its counter. With no new key pair, no further overflow follows.
- R8: When bit 3 of the auxiliary register is clear, `rst_pin_drv` rises together with `wdt_rst` and stays high for exactly 98 clock cycles.
- R9: The auxiliary register is written at address 0x8E. Its bit 3 resets to 0. When that bit is 1 at the overflow, `rst_pin_drv` stays low, and `wdt_rst` still pulses.
- R10: A hardware reset while armed disarms the watchdog, and no overflow follows unless the watchdog is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| mc_tick | input | 1 | Machine-cycle tick; advances the counter |
| wdt_rst | output | 1 | One-cycle chip reset request on overflow |
| rst_pin_drv | output | 1 | Stretched reset-out drive, 98 clocks |

## Verification
On every cycle, the embedded assertions check four things. The enable rises only on an accepted key and falls only on an overflow. The counter steps by one per tick while armed. The overflow leaves the counter cleared and disarmed. The reset-out line starts, or stays quiet, according to the suppress bit. Other behaviours only the bench scenarios can show, because each spans thousands of cycles or depends on what did not happen:
- the exact overflow cycle after an arm or a kick,
- the 98-cycle length of the pulse,
- rejection of broken key sequences,
- silence after an overflow or after a hardware reset.

// File: rtl/wdog_pkg.sv
// Shared types for the keyed watchdog.
// Assumes: single clock domain, synchronous active-low reset.
package wdog_pkg;
    typedef enum logic {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdog_keyseq.sv
// Key sequencer: recognises the arm/kick pair written to the watchdog
// register. The state tracks writes only; idle cycles keep it unchanged.
// Assumes: at most one write per cycle.
module wdog_keyseq #(
    parameter logic [7:0] WDT_ADDR   = 8'hA6,
    parameter logic [7:0] KEY_FIRST  = 8'h1E,
    parameter logic [7:0] KEY_SECOND = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       key_ok
);
    import wdog_pkg::*;

    key_state_e state_q;
    logic       hit_first;
    logic       hit_second;

    // Decode the current write against both key bytes.
    always_comb begin
        hit_first  = wr_en && (wr_addr == WDT_ADDR) && (wr_data == KEY_FIRST);
        hit_second = wr_en && (wr_addr == WDT_ADDR) && (wr_data == KEY_SECOND);
        key_ok     = hit_second && (state_q == KEY_HALF);
    end

    // Every write either opens a new half-sequence or discards the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else if (wr_en) begin
            state_q <= hit_first ? KEY_HALF : KEY_IDLE;
        end
    end

    // R3
    key_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_first) |=> !key_ok || !$past(wr_en) || $past(hit_first));
endmodule

// File: rtl/wdog_core.sv
// Watchdog core: the enable flag and the machine-cycle counter.
// An accepted key arms the counter or clears it. A tick at the top count
// overflows it, and the overflow disarms and clears it.
// Assumes: key_ok and tick come from the same clock domain.
module wdog_core #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic tick,
    output logic ovf_now,
    output logic wdt_rst
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // The overflow fires when a tick meets the top count; a key takes priority.
    always_comb begin
        ovf_now = armed_q && tick && !key_ok && (cnt_q == CNT_MAX);
    end

    // Enable flag and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (key_ok) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (ovf_now) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q && tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // One-cycle reset request registered from the overflow event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= ovf_now;
        end
    end

    // R2
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(key_ok));

    // R6
    disarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_q) |-> $past(ovf_now));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && !key_ok && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (!armed_q && cnt_q == '0));
endmodule

// File: rtl/wdog_stretch.sv
// Reset-out stretcher: turns an overflow event into a fixed-length
// high pulse, unless the suppress input is set at the event.
// Assumes: triggers are spaced further apart than LEN cycles.
module wdog_stretch #(
    parameter int LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic suppress,
    output logic pin_drv
);
    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] left_q;

    // Load the remaining length on an unsuppressed trigger, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trigger && !suppress) begin
            left_q <= PW'(LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // The drive is high while any length remains.
    always_comb begin
        pin_drv = (left_q != '0);
    end

    // R8
    pin_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && !suppress) |=> pin_drv);

    // R9
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && suppress && !pin_drv) |=> !pin_drv);
endmodule

// File: rtl/wdog_top.sv
// Keyed one-time-enable watchdog. This top module joins three parts: the
// key sequencer, the counter core and the reset-out stretcher. It also
// holds the auxiliary register bit that suppresses the reset-out drive.
// Assumes: mc_tick is a single-cycle pulse per machine cycle.
module wdog_top #(
    parameter int         CNT_W      = 14,
    parameter int         PULSE_LEN  = 98,
    parameter logic [7:0] WDT_ADDR   = 8'hA6,
    parameter logic [7:0] AUX_ADDR   = 8'h8E,
    parameter logic [7:0] KEY_FIRST  = 8'h1E,
    parameter logic [7:0] KEY_SECOND = 8'hE1,
    parameter int         DIS_BIT    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       mc_tick,
    output logic       wdt_rst,
    output logic       rst_pin_drv
);
    logic key_ok;
    logic ovf_now;
    logic pin_off_q;

    // Auxiliary register: only the reset-out suppress bit is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_off_q <= 1'b0;
        end else if (wr_en && (wr_addr == AUX_ADDR)) begin
            pin_off_q <= wr_data[DIS_BIT];
        end
    end

    wdog_keyseq #(
        .WDT_ADDR   (WDT_ADDR),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .key_ok  (key_ok)
    );

    wdog_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_ok  (key_ok),
        .tick    (mc_tick),
        .ovf_now (ovf_now),
        .wdt_rst (wdt_rst)
    );

    wdog_stretch #(
        .LEN (PULSE_LEN)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (ovf_now),
        .suppress (pin_off_q),
        .pin_drv  (rst_pin_drv)
    );

    // R8
    pin_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst && !$past(pin_off_q)) |-> rst_pin_drv);
endmodule

// File: tb/tb_wdog_top.sv
// Scoreboard bench for wdog_top. A model process predicts each overflow
// from the port activity and queues it. A monitor pops the queued items
// and compares the cycle and the pulse length.
module tb_wdog_top;
    localparam int TICKS = 16384;
    localparam int PLEN  = 98;

    typedef struct {
        int cyc;
        int len;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       mc_tick = 1'b0;
    logic       wdt_rst;
    logic       rst_pin_drv;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   ev_seen = 0;
    bit   half_tick = 1'b0;
    bit   done = 1'b0;
    exp_t expq[$];

    // Model state
    bit m_half = 1'b0;
    bit m_armed = 1'b0;
    int m_cnt = 0;
    bit m_dis = 1'b0;

    wdog_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mc_tick     (mc_tick),
        .wdt_rst     (wdt_rst),
        .rst_pin_drv (rst_pin_drv)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Tick driver: every cycle, or every other cycle in half mode.
    initial begin
        forever begin
            @(negedge clk);
            mc_tick = half_tick ? ~mc_tick : 1'b1;
        end
    end

    // Model of the requirements; port inputs are stable at posedge.
    always @(posedge clk) begin
        bit kick;
        cyc++;
        if (!rst_n) begin
            m_half = 0; m_armed = 0; m_cnt = 0; m_dis = 0;
        end else begin
            kick = wr_en && wr_addr == 8'hA6 && wr_data == 8'hE1 && m_half;
            if (kick) begin
                m_armed = 1; m_cnt = 0;
            end else if (m_armed && mc_tick) begin
                if (m_cnt == TICKS - 1) begin
                    expq.push_back('{cyc: cyc, len: (m_dis ? 0 : PLEN)});
                    m_armed = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
            if (wr_en) m_half = (wr_addr == 8'hA6 && wr_data == 8'h1E);
            if (wr_en && wr_addr == 8'h8E) m_dis = wr_data[3];
        end
    end

    // Monitor: pops each expected overflow and measures the pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wdt_rst) begin
                int n;
                exp_t it;
                ev_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected overflow", cyc, -1);
                end else begin
                    it = expq.pop_front();
                    // R4 overflow cycle
                    check(it.cyc == cyc, "R4 overflow cycle", cyc, it.cyc);
                    n = 0;
                    while (rst_pin_drv && n < 300) begin
                        n++;
                        @(negedge clk);
                    end
                    // R8 / R9 pulse length
                    check(n == it.len, "R8/R9 pulse length", n, it.len);
                end
            end else if (rst_n && rst_pin_drv) begin
                check(1'b0, "R8 stray reset-out", 1, 0);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
        wr_end();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1 reset state
        idle(4);
        check(wdt_rst == 1'b0, "R1 wdt_rst in reset", wdt_rst, 0);
        check(rst_pin_drv == 1'b0, "R1 pin in reset", rst_pin_drv, 0);
        rst_n = 1'b1;
        idle(1);
        check(wdt_rst == 1'b0 && rst_pin_drv == 1'b0, "R1 after release", wdt_rst, 0);

        // R3 broken sequences
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE2);
        wr(8'hA6, 8'h1E); wr(8'h80, 8'h00); wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'hE1);
        wr_end();
        idle(16600);
        check(ev_seen == 0, "R3 no arm from broken key", ev_seen, 0);

        // R2 R4 R8 arm with gapped key writes, then overflow
        wr(8'hA6, 8'h1E); wr_end(); idle(3);
        wr(8'hA6, 8'hE1); wr_end();
        idle(16600);
        check(ev_seen == 1, "R2 arm then overflow", ev_seen, 1);

        // R7 disarmed after overflow
        idle(16600);
        check(ev_seen == 1, "R7 no overflow after disarm", ev_seen, 1);

        // R5 R6 kick postpones the overflow; other writes do not disarm
        arm();
        idle(10000);
        wr(8'hA6, 8'h00); wr_end();
        arm();
        idle(10000);
        check(ev_seen == 1, "R5 kick postponed overflow", ev_seen, 1);
        idle(7000);
        check(ev_seen == 2, "R6 still armed after write", ev_seen, 2);

        // R9 suppress bit with half-rate ticks
        wr(8'h8E, 8'h08); wr_end();
        half_tick = 1'b1;
        arm();
        idle(33000);
        check(ev_seen == 3, "R9 overflow still requested", ev_seen, 3);
        half_tick = 1'b0;
        wr(8'h8E, 8'h00); wr_end();

        // R10 hardware reset while armed
        arm();
        idle(1000);
        rst_n = 1'b0;
        idle(2);
        check(wdt_rst == 1'b0 && rst_pin_drv == 1'b0, "R10 outputs in reset", wdt_rst, 0);
        rst_n = 1'b1;
        idle(16600);
        check(ev_seen == 3, "R10 disarmed by reset", ev_seen, 3);
        check(expq.size() == 0, "R7 scoreboard drained", expq.size(), 0);
        finish_run();
    end
endmodule